// File: doc/BRIEF.md
# Moore-Style Bit-Serial Unsigned Adder

This block adds two unsigned operands one bit per clock, starting from the least significant bit. Both operands are captured in right-shifting registers. A four-state machine absorbs one pair of operand bits on each step. Its state holds the running carry and the sum bit for the pair it has just absorbed. The sum bit is taken from the state alone, so it appears one clock after its operand bits. A third shift register gathers these bits from the top end down, and the finished word ends up aligned with bit 0.

A run starts when the synchronous reset is asserted with the operands on the inputs. The reset captures the operands, clears the sum register and the machine, and loads the step counter. After the reset is released, the operands take part for WIDTH clocks. The sum register takes in WIDTH bits, and it starts one clock late because of the registered sum bit. When the counter runs out, the done flag rises. The sum and the carry out of the top bit then stay fixed until the next reset. The carry out is reported on its own pin and is never folded into the sum word.

Top module: `serialAdderMoore`

## Requirements
- R1: At the first clock edge with reset high, sum becomes 0, carryOut becomes 0 and done becomes 0, whatever the state was before.
- R2: done is 0 for the first WIDTH clock edges after reset is released, and goes to 1 at the (WIDTH+1)-th edge.
- R3: When done is 1, sum equals (opA + opB) modulo 2^WIDTH, where opA and opB are the values captured at the reset edge.
- R4: When done is 1, carryOut equals bit WIDTH of opA + opB, which is the carry out of the most significant bit.
- R5: Once done is 1 and reset stays low, sum, carryOut and done do not change.
- R6: The sum register receives no bit at the first edge after reset. At edge k, for 2 ≤ k ≤ WIDTH+1, its top k-1 bits hold the low k-1 bits of the true sum, with the least significant of these at position WIDTH-k+1, and every bit below that is 0.
- R7: Asserting reset in the middle of a run throws that run away. The new operands are captured and the result follows R2 to R4 for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| reset | input | 1 | Synchronous; captures operands and starts a run |
| opA | input | WIDTH | First operand, sampled at a reset edge |
| opB | input | WIDTH | Second operand, sampled at a reset edge |
| sum | output | WIDTH | Sum shift register contents |
| carryOut | output | 1 | Carry held in the machine state |
| done | output | 1 | High once all sum bits are in place |

## Verification
The hardest thing to see from the ports is the one-clock lag of the Moore output: the sum register must sit still on the first edge and then fill from the top one bit per edge. A register off by one still shows a plausible final value for many operand pairs. The bench therefore checks the partial contents of sum after every edge of each run against a mask of the reference sum. It sweeps a grid of operand pairs and a full row against 255, which covers every carry chain length. A reset is also injected halfway through a run.

// File: rtl/serAddPkg.sv
package serAddPkg;
  typedef struct packed {
    logic load;      // capture operands, clear sum and state
    logic advance;   // absorb one operand bit pair
    logic shiftSum;  // take the state's sum bit into the result
  } serAddStrobes_t;

  typedef enum logic [1:0] {
    C0S0 = 2'b00,
    C0S1 = 2'b01,
    C1S0 = 2'b10,
    C1S1 = 2'b11
  } adderState_t;
endpackage

// File: rtl/serAddCtrl.sv
module serAddCtrl
  import serAddPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic           clk,
  input  logic           reset,
  output serAddStrobes_t strobes,
  output logic           done
);
  localparam int CNT_W = $clog2(WIDTH + 2);
  localparam logic [CNT_W-1:0] START = CNT_W'(WIDTH + 1);

  logic [CNT_W-1:0] stepCnt;
  logic active;

  assign active = (stepCnt != '0);

  always_ff @(posedge clk) begin
    if (reset) stepCnt <= START;
    else if (active) stepCnt <= stepCnt - 1'b1;
  end

  always_comb begin
    strobes.load     = reset;
    strobes.advance  = !reset && (stepCnt > CNT_W'(1));
    strobes.shiftSum = !reset && active && (stepCnt != START);
  end

  assign done = !active;
endmodule

// File: rtl/serAddData.sv
module serAddData
  import serAddPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  serAddStrobes_t   strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             bitA,
  output logic             bitB,
  input  logic             sumBit,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] regA, regB;

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      regA <= opA;
      regB <= opB;
    end else if (strobes.advance) begin
      regA <= {1'b0, regA[WIDTH-1:1]};
      regB <= {1'b0, regB[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.load) sum <= '0;
    else if (strobes.shiftSum) sum <= {sumBit, sum[WIDTH-1:1]};
  end

  assign bitA = regA[0];
  assign bitB = regB[0];
endmodule

// File: rtl/serAddFsm.sv
module serAddFsm
  import serAddPkg::*;
(
  input  logic           clk,
  input  serAddStrobes_t strobes,
  input  logic           bitA,
  input  logic           bitB,
  output logic           sumBit,
  output logic           carry
);
  adderState_t state, nextState;
  logic [1:0] pairTotal;

  always_comb begin
    pairTotal = {1'b0, bitA} + {1'b0, bitB} + {1'b0, state[1]};
    unique case (pairTotal)
      2'd0:    nextState = C0S0;
      2'd1:    nextState = C0S1;
      2'd2:    nextState = C1S0;
      default: nextState = C1S1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.load) state <= C0S0;
    else if (strobes.advance) state <= nextState;
  end

  assign sumBit = state[0];
  assign carry  = state[1];
endmodule

// File: rtl/serialAdderMoore.sv
module serialAdderMoore
  import serAddPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             reset,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             done
);
  serAddStrobes_t strobes;
  logic bitA, bitB, sumBit;

  serAddCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .reset(reset), .strobes(strobes), .done(done)
  );

  serAddData #(.WIDTH(WIDTH)) uData (
    .clk(clk), .strobes(strobes), .opA(opA), .opB(opB),
    .bitA(bitA), .bitB(bitB), .sumBit(sumBit), .sum(sum)
  );

  serAddFsm uFsm (
    .clk(clk), .strobes(strobes), .bitA(bitA), .bitB(bitB),
    .sumBit(sumBit), .carry(carryOut)
  );
endmodule

// File: rtl/serAddChecker.sv
module serAddChecker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             reset,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] sum,
  input logic             carryOut,
  input logic             done
);
  localparam int CW = $clog2(WIDTH + 3);
  logic seenReset = 1'b0;
  logic [CW-1:0] sinceReset = '0;
  logic [WIDTH:0] capTotal = '0;

  always_ff @(posedge clk) begin
    if (reset) begin
      seenReset  <= 1'b1;
      sinceReset <= '0;
      capTotal   <= {1'b0, opA} + {1'b0, opB};
    end else if (seenReset && sinceReset < CW'(WIDTH + 2)) begin
      sinceReset <= sinceReset + 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    reset |=> (sum == '0 && !carryOut && !done));

  // R2
  done_timing_chk: assert property (@(posedge clk) disable iff (reset)
    (seenReset && !$past(reset)) |-> (done == (sinceReset >= CW'(WIDTH + 1))));

  // R3
  sum_value_chk: assert property (@(posedge clk) disable iff (reset)
    (seenReset && done) |-> (sum == capTotal[WIDTH-1:0]));

  // R4
  carry_value_chk: assert property (@(posedge clk) disable iff (reset)
    (seenReset && done) |-> (carryOut == capTotal[WIDTH]));

  // R5
  hold_after_done_chk: assert property (@(posedge clk) disable iff (reset)
    (seenReset && done) |=> (done && $stable(sum) && $stable(carryOut)));

  // R6
  first_step_idle_chk: assert property (@(posedge clk)
    reset |=> ##1 (sum == '0));
endmodule

bind serialAdderMoore serAddChecker #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .reset(reset), .opA(opA), .opB(opB),
  .sum(sum), .carryOut(carryOut), .done(done)
);

// File: tb/tb_serialAdderMoore.sv
`timescale 1ns/1ps
module tb_serialAdderMoore;
  localparam int W = 8;

  logic clk = 1'b0;
  logic reset = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [W-1:0] sum;
  logic carryOut, done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  serialAdderMoore #(.WIDTH(W)) dut (
    .clk(clk), .reset(reset), .opA(opA), .opB(opB),
    .sum(sum), .carryOut(carryOut), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] partial(input logic [W:0] total, input int m);
    logic [W-1:0] low;
    if (m <= 0) return '0;
    low = total[W-1:0] & W'((1 << m) - 1);
    return W'(low << (W - m));
  endfunction

  task automatic startRun(input logic [W-1:0] a, input logic [W-1:0] b);
    opA = a; opB = b; reset = 1'b1;
    @(posedge clk); #1;
    reset = 1'b0;
    opA = ~a; opB = ~b;  // inputs must not matter outside reset
    check("R1 sum", sum, 0);
    check("R1 carryOut", carryOut, 0);
    check("R1 done", done, 0);
  endtask

  task automatic runAdd(input logic [W-1:0] a, input logic [W-1:0] b, input bit detail);
    logic [W:0] total;
    total = {1'b0, a} + {1'b0, b};
    startRun(a, b);
    for (int k = 1; k <= W + 1; k++) begin
      @(posedge clk); #1;
      if (detail || k == 1) check("R6 partial sum", sum, partial(total, k - 1));
      if (detail || k >= W) check("R2 done", done, (k == W + 1));
    end
    check("R3 sum", sum, total[W-1:0]);
    check("R4 carryOut", carryOut, total[W]);
    repeat (2) @(posedge clk);
    #1;
    check("R5 sum held", sum, total[W-1:0]);
    check("R5 carry held", carryOut, total[W]);
    check("R5 done held", done, 1);
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // corner pairs
    runAdd(8'd0,   8'd0,   1'b1);
    runAdd(8'd255, 8'd1,   1'b1);
    runAdd(8'd255, 8'd255, 1'b1);
    runAdd(8'd128, 8'd128, 1'b1);
    runAdd(8'd85,  8'd170, 1'b1);
    // full row against 255: every carry chain length
    for (int b = 0; b < 256; b++) runAdd(8'd255, W'(b), 1'b0);
    // grid sweep
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 13) runAdd(W'(a), W'(b), (a == b));
    // R7: reset in the middle of a run
    startRun(8'd200, 8'd100);
    repeat (4) @(posedge clk);
    #1;
    runAdd(8'd77, 8'd190, 1'b1);
    check("R7 restart sum", sum, 8'((77 + 190) % 256));
    check("R7 restart carry", carryOut, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule